// File: doc/BRIEF.md
# Execute Packet Dispatcher for an Eight-Slot Wide-Issue Core

This block sits between instruction fetch and the functional units of a wide-issue core. It takes in one fetch packet at a time. A fetch packet is eight 32-bit instruction words, 256 bits in all. The block cuts the packet into execute packets by following a chain of per-instruction parallel flags. It then issues one execute packet per clock cycle. Each issue goes out on eight output lanes, and each lane is tied to one functional unit. The core has two sides, A and B. Each side has a logic, a shift, a multiply and a data unit.

Each instruction names its target unit in a three-bit unit field. The dispatcher sends every instruction of the current execute packet to the lane of that unit. While a held fetch packet still has more than the execute packet now being issued, the fetch handshake is held off. When two instructions of one execute packet name the same unit, the block flags a conflict. It also flags any fetch packet whose byte address is not aligned to the 32-byte packet size.

Top module: `vliw_issue_dispatcher`

## Requirements
- R1: Reset is synchronous and active high. After reset, `fp_ready` is 1 and `issue_valid`, `slot_valid`, `conflict` and `misaligned` are all 0.
- R2: A fetch packet is taken on a rising edge where `fp_valid` and `fp_ready` are both 1. Its first execute packet shows on the outputs after the second rising edge from that one.
- R3: Bit 0 of each instruction is its parallel flag. Instructions are scanned from word 0 (bits 31:0) up to word 7. An execute packet starting at word s takes in word s+1 when word s has the flag set, and so on. It ends at the first word whose flag is clear.
- R4: The parallel flag of word 7 is ignored. An execute packet never continues into the next fetch packet.
- R5: Bits 3:1 of an instruction select its unit. The codes are 0 logic A, 1 shift A, 2 multiply A, 3 data A, 4 logic B, 5 shift B, 6 multiply B, 7 data B. Lane u (`slot_valid[u]`, `slot_instr[32u+31:32u]`) carries the instruction that selects unit u.
- R6: The execute packets of a fetch packet issue on consecutive cycles with no gap. Back-to-back fetch packets also issue with no gap between them.
- R7: `fp_ready` is 0 while the held packet still has execute packets beyond the one issuing at the next edge. A fetch packet with N execute packets therefore holds off the next packet for N-1 cycles.
- R8: If two or more instructions in one execute packet select the same unit, `conflict` is 1 together with that issue. The lane carries the lowest-addressed of those instructions, and the others are dropped.
- R9: `misaligned` pulses for one cycle, in the cycle after a packet is taken, when the low five bits of `fp_addr` (a byte address) are nonzero. The packet is still dispatched normally.
- R10: A lane whose `slot_valid` bit is 0 carries an all-zero instruction word.
- R11: `issue_valid` is 1 exactly when at least one `slot_valid` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Dispatcher can take a fetch packet |
| fp_addr | input | 32 | Byte address of the offered fetch packet |
| fp_data | input | 256 | Eight instruction words, word 0 in bits 31:0 |
| issue_valid | output | 1 | An execute packet is on the lanes |
| slot_valid | output | 8 | Per-unit lane valid |
| slot_instr | output | 256 | Per-unit lane instruction, lane u in bits 32u+31:32u |
| conflict | output | 1 | Two instructions of the issued packet chose one unit |
| misaligned | output | 1 | Pulse for a taken packet with a misaligned address |

## Verification
Two functions can fall in the same cycle. One is the last execute packet of a held fetch packet being issued. The other is a new fetch packet being taken through the handshake. The bench provokes this by offering a second packet at once after the first, while the first still has several execute packets left. It counts the cycles that `fp_ready` stays low and compares the count with the number of execute packets minus one. It then checks that the first issue of the new packet lands on the cycle right after the last issue of the old one. This shows the overlap loses no cycle and no packet spills across the boundary.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;

  // Functional unit codes, in the order they are selected by the unit field.
  typedef enum logic [2:0] {
    FU_LOGIC_A = 3'd0,
    FU_SHIFT_A = 3'd1,
    FU_MULT_A  = 3'd2,
    FU_DATA_A  = 3'd3,
    FU_LOGIC_B = 3'd4,
    FU_SHIFT_B = 3'd5,
    FU_MULT_B  = 3'd6,
    FU_DATA_B  = 3'd7
  } fu_e;

  localparam int FU_SEL_W = 3;

endpackage

// File: rtl/vliw_fetch_hold.sv
// Holds one fetch packet, tracks the start of the next execute packet and
// drives the fetch handshake.
module vliw_fetch_hold #(
  parameter int SLOTS   = 8,
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 32,
  localparam int POS_W      = $clog2(SLOTS),
  localparam int PKT_W      = SLOTS * INSTR_W,
  localparam int ALIGN_BITS = $clog2(PKT_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fp_valid,
  output logic              fp_ready,
  input  logic [ADDR_W-1:0] fp_addr,
  input  logic [PKT_W-1:0]  fp_data,
  input  logic              span_last,
  input  logic [POS_W-1:0]  span_next,
  output logic [PKT_W-1:0]  held_pkt,
  output logic [POS_W-1:0]  start_pos,
  output logic              busy,
  output logic              misalign_q
);

  logic take;

  // Ready one cycle early: the final execute packet issues on the same edge
  // that takes the next fetch packet.
  assign fp_ready = !busy || span_last;
  assign take     = fp_valid && fp_ready;

  always_ff @(posedge clk) begin
    if (take) held_pkt <= fp_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      start_pos  <= '0;
      misalign_q <= 1'b0;
    end else begin
      misalign_q <= take && (fp_addr[ALIGN_BITS-1:0] != '0);
      if (take) begin
        busy      <= 1'b1;
        start_pos <= '0;
      end else if (busy) begin
        if (span_last) busy <= 1'b0;
        else           start_pos <= span_next;
      end
    end
  end

endmodule

// File: rtl/vliw_ep_span.sv
// Marks the words of the execute packet that starts at start_pos by
// following the parallel-flag chain. The last word's flag plays no part.
module vliw_ep_span #(
  parameter int SLOTS = 8,
  localparam int POS_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] par_flag,
  input  logic [POS_W-1:0] start_pos,
  output logic [SLOTS-1:0] member,
  output logic [POS_W-1:0] next_pos,
  output logic             reaches_end
);

  assign member[0] = (start_pos == '0);

  generate
    for (genvar j = 1; j < SLOTS; j++) begin : g_chain
      assign member[j] = (start_pos == POS_W'(j)) || (member[j-1] && par_flag[j-1]);
    end
  endgenerate

  always_comb begin
    next_pos = '0;
    for (int j = 0; j < SLOTS - 1; j++) begin
      if (member[j]) next_pos = POS_W'(j + 1);
    end
  end

  assign reaches_end = member[SLOTS-1];

endmodule

// File: rtl/vliw_unit_router.sv
// Routes the members of one execute packet to per-unit lanes. The lowest
// addressed claimant of a unit wins, and extra claimants raise a conflict.
module vliw_unit_router
  import vliw_disp_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int INSTR_W  = 32,
  parameter int UNITS    = 8,
  parameter int UNIT_LSB = 1,
  localparam int SEL_W   = $clog2(UNITS),
  localparam int PKT_W   = SLOTS * INSTR_W,
  localparam int LANE_W  = UNITS * INSTR_W
) (
  input  logic [PKT_W-1:0]  pkt,
  input  logic [SLOTS-1:0]  member,
  output logic [UNITS-1:0]  lane_valid,
  output logic [LANE_W-1:0] lane_instr,
  output logic              conflict
);

  logic [UNITS-1:0] dup;

  generate
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      logic [SLOTS-1:0]   hit;
      logic [INSTR_W-1:0] pick;

      always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
          hit[j] = member[j] && (pkt[j*INSTR_W+UNIT_LSB +: SEL_W] == SEL_W'(u));
        end
      end

      // Priority: scan high to low so the lowest index is written last.
      always_comb begin
        pick = '0;
        for (int j = SLOTS - 1; j >= 0; j--) begin
          if (hit[j]) pick = pkt[j*INSTR_W +: INSTR_W];
        end
      end

      assign lane_valid[u]                  = |hit;
      assign lane_instr[u*INSTR_W +: INSTR_W] = pick;
      assign dup[u]                          = |(hit & (hit - SLOTS'(1)));
    end
  endgenerate

  assign conflict = |dup;

endmodule

// File: rtl/vliw_issue_dispatcher.sv
// Top level: fetch packet holding, execute packet span, unit routing and
// registered issue lanes.
module vliw_issue_dispatcher
  import vliw_disp_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int INSTR_W  = 32,
  parameter int UNITS    = 8,
  parameter int ADDR_W   = 32,
  parameter int UNIT_LSB = 1,
  localparam int POS_W   = $clog2(SLOTS),
  localparam int PKT_W   = SLOTS * INSTR_W,
  localparam int LANE_W  = UNITS * INSTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fp_valid,
  output logic              fp_ready,
  input  logic [ADDR_W-1:0] fp_addr,
  input  logic [PKT_W-1:0]  fp_data,
  output logic              issue_valid,
  output logic [UNITS-1:0]  slot_valid,
  output logic [LANE_W-1:0] slot_instr,
  output logic              conflict,
  output logic              misaligned
);

  logic [PKT_W-1:0]  held_pkt;
  logic [POS_W-1:0]  start_pos;
  logic [POS_W-1:0]  span_next;
  logic              span_last;
  logic              busy;
  logic [SLOTS-1:0]  par_flag;
  logic [SLOTS-1:0]  member;
  logic [UNITS-1:0]  lane_valid;
  logic [LANE_W-1:0] lane_instr;
  logic              lane_conflict;

  generate
    for (genvar j = 0; j < SLOTS; j++) begin : g_par
      assign par_flag[j] = held_pkt[j*INSTR_W];
    end
  endgenerate

  vliw_fetch_hold #(
    .SLOTS(SLOTS), .INSTR_W(INSTR_W), .ADDR_W(ADDR_W)
  ) u_hold (
    .clk(clk), .rst(rst),
    .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_addr(fp_addr), .fp_data(fp_data),
    .span_last(span_last), .span_next(span_next),
    .held_pkt(held_pkt), .start_pos(start_pos),
    .busy(busy), .misalign_q(misaligned)
  );

  vliw_ep_span #(.SLOTS(SLOTS)) u_span (
    .par_flag(par_flag), .start_pos(start_pos),
    .member(member), .next_pos(span_next), .reaches_end(span_last)
  );

  vliw_unit_router #(
    .SLOTS(SLOTS), .INSTR_W(INSTR_W), .UNITS(UNITS), .UNIT_LSB(UNIT_LSB)
  ) u_route (
    .pkt(held_pkt), .member(member),
    .lane_valid(lane_valid), .lane_instr(lane_instr), .conflict(lane_conflict)
  );

  // Registered issue stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      slot_valid  <= '0;
      slot_instr  <= '0;
      conflict    <= 1'b0;
    end else if (busy) begin
      issue_valid <= 1'b1;
      slot_valid  <= lane_valid;
      slot_instr  <= lane_instr;
      conflict    <= lane_conflict;
    end else begin
      issue_valid <= 1'b0;
      slot_valid  <= '0;
      slot_instr  <= '0;
      conflict    <= 1'b0;
    end
  end

endmodule

// File: rtl/vliw_disp_chk.sv
module vliw_disp_chk #(
  parameter int UNITS   = 8,
  parameter int INSTR_W = 32,
  parameter int SLOTS   = 8,
  parameter int ADDR_W  = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     fp_valid,
  input logic                     fp_ready,
  input logic [ADDR_W-1:0]        fp_addr,
  input logic [SLOTS*INSTR_W-1:0] fp_data,
  input logic                     issue_valid,
  input logic [UNITS-1:0]         slot_valid,
  input logic [UNITS*INSTR_W-1:0] slot_instr,
  input logic                     conflict,
  input logic                     misaligned
);

  // R2: a taken packet issues after the second edge.
  p_take_issues_r2: assert property (@(posedge clk) disable iff (rst)
    (fp_valid && fp_ready) |=> ##1 issue_valid);

  // R7: a stalled handshake means an execute packet issues next.
  p_stall_issues_r7: assert property (@(posedge clk) disable iff (rst)
    !fp_ready |=> issue_valid);

  // R8: a conflict is reported only alongside an issue.
  p_conflict_issue_r8: assert property (@(posedge clk) disable iff (rst)
    conflict |-> (issue_valid && $countones(slot_valid) >= 1));

  // R9: a misalignment pulse follows a take.
  p_misalign_take_r9: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> $past(fp_valid && fp_ready));

  // R11: issue flag matches lane valids.
  p_issue_flag_r11: assert property (@(posedge clk) disable iff (rst)
    issue_valid == (slot_valid != '0));

  generate
    for (genvar u = 0; u < UNITS; u++) begin : g_lane
      // R10: idle lanes carry zero.
      p_idle_lane_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !slot_valid[u] |-> (slot_instr[u*INSTR_W +: INSTR_W] == '0));
    end
  endgenerate

endmodule

bind vliw_issue_dispatcher vliw_disp_chk #(
  .UNITS(UNITS), .INSTR_W(INSTR_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sim_vliw_issue_dispatcher.sv
`timescale 1ns/1ps
module sim_vliw_issue_dispatcher;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fp_valid = 1'b0;
  logic [31:0]  fp_addr = '0;
  logic [255:0] fp_data = '0;
  logic         fp_ready;
  logic         issue_valid;
  logic [7:0]   slot_valid;
  logic [255:0] slot_instr;
  logic         conflict;
  logic         misaligned;

  always #2.5 clk = ~clk;

  vliw_issue_dispatcher u0 (
    .clk(clk), .rst(rst), .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_addr(fp_addr), .fp_data(fp_data), .issue_valid(issue_valid),
    .slot_valid(slot_valid), .slot_instr(slot_instr),
    .conflict(conflict), .misaligned(misaligned)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor (never cleared; tests use a base index).
  logic [7:0]   m_val [256];
  logic [255:0] m_ins [256];
  logic         m_conf[256];
  logic         m_flag[256];
  int           m_cyc [256];
  int           m_n = 0;
  int           mis_n = 0;
  int           mis_cyc = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (issue_valid || slot_valid != 8'h0) begin
        if (m_n < 256) begin
          m_val[m_n]  = slot_valid;
          m_ins[m_n]  = slot_instr;
          m_conf[m_n] = conflict;
          m_flag[m_n] = issue_valid;
          m_cyc[m_n]  = cyc;
        end
        m_n = m_n + 1;
      end
      if (misaligned) begin
        mis_n   = mis_n + 1;
        mis_cyc = cyc;
      end
    end
  end

  // Expected execute packets.
  logic [7:0]   e_val [64];
  logic [255:0] e_ins [64];
  logic         e_conf[64];
  int           e_n = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int unit, input bit par);
    logic [27:0] t;
    t = 28'(32'h0A5C000 + tag);
    return {t, 3'(unit), par};
  endfunction

  // Model of R3, R4, R5, R8: group by parallel flag, route by unit field.
  task automatic model_pkt(input logic [255:0] p);
    int s;
    s = 0;
    while (s < 8) begin
      logic [7:0]   v;
      logic [255:0] ins;
      logic         cf;
      int           last;
      v = '0; ins = '0; cf = 1'b0; last = 7;
      for (int j = s; j < 8; j++) begin
        int u;
        u = int'(p[j*32+1 +: 3]);
        if (v[u]) cf = 1'b1;
        else begin
          v[u] = 1'b1;
          ins[u*32 +: 32] = p[j*32 +: 32];
        end
        if (j == 7 || !p[j*32]) begin
          last = j;
          break;
        end
      end
      e_val[e_n] = v; e_ins[e_n] = ins; e_conf[e_n] = cf;
      e_n++;
      s = last + 1;
    end
  endtask

  task automatic send(input logic [31:0] addr, input logic [255:0] p,
                      output int stalls, output int acc_c);
    stalls = 0;
    fp_valid = 1'b1; fp_addr = addr; fp_data = p;
    while (!fp_ready) begin
      stalls++;
      @(negedge clk);
    end
    acc_c = cyc;
    @(negedge clk);
    fp_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (14) @(negedge clk);
  endtask

  task automatic compare(input int base, input int acc_c, input string tag);
    check(m_n - base == e_n, "R6", {tag, " execute packet count"}, 64'(m_n - base), 64'(e_n));
    check(m_cyc[base] == acc_c + 2, "R2", {tag, " first issue cycle"}, 64'(m_cyc[base]), 64'(acc_c + 2));
    for (int i = 0; i < e_n && i < m_n - base; i++) begin
      check(m_val[base+i] == e_val[i], "R3", {tag, " lane valid mask"}, 64'(m_val[base+i]), 64'(e_val[i]));
      check(m_conf[base+i] == e_conf[i], "R8", {tag, " conflict"}, 64'(m_conf[base+i]), 64'(e_conf[i]));
      check(m_flag[base+i] == (e_val[i] != 0), "R11", {tag, " issue flag"}, 64'(m_flag[base+i]), 64'(e_val[i] != 0));
      check(m_cyc[base+i] == m_cyc[base] + i, "R6", {tag, " issue cycle"}, 64'(m_cyc[base+i]), 64'(m_cyc[base] + i));
      for (int u = 0; u < 8; u++) begin
        // R5 for valid lanes, R10 for idle lanes (expected zero).
        check(m_ins[base+i][u*32 +: 32] == e_ins[i][u*32 +: 32],
              e_val[i][u] ? "R5" : "R10", {tag, " lane word"},
              64'(m_ins[base+i][u*32 +: 32]), 64'(e_ins[i][u*32 +: 32]));
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(fp_ready == 1'b1, "R1", "ready after reset", 64'(fp_ready), 64'd1);
    check(issue_valid == 1'b0, "R1", "issue after reset", 64'(issue_valid), 64'd0);
    check(slot_valid == 8'h0, "R1", "lanes after reset", 64'(slot_valid), 64'd0);
    check(conflict == 1'b0, "R1", "conflict after reset", 64'(conflict), 64'd0);
    check(misaligned == 1'b0, "R1", "misaligned after reset", 64'(misaligned), 64'd0);
  endtask

  task automatic t_serial();
    logic [255:0] p;
    int base, st, ac;
    for (int j = 0; j < 8; j++) p[j*32 +: 32] = mk(16 + j, 7 - j, 1'b0);
    e_n = 0; model_pkt(p);
    base = m_n;
    send(32'h0000_0200, p, st, ac);
    drain();
    check(st == 0, "R7", "serial stall count", 64'(st), 64'd0);
    compare(base, ac, "serial");
  endtask

  task automatic t_parallel();
    logic [255:0] p;
    int base, st, ac;
    int perm [8] = '{3, 0, 6, 1, 5, 2, 7, 4};
    for (int j = 0; j < 8; j++) p[j*32 +: 32] = mk(32 + j, perm[j], j != 7);
    e_n = 0; model_pkt(p);
    base = m_n;
    send(32'h0000_0400, p, st, ac);
    drain();
    check(m_val[base] == 8'hFF, "R3", "all eight issue together", 64'(m_val[base]), 64'hFF);
    compare(base, ac, "parallel");
  endtask

  task automatic t_back_to_back();
    logic [255:0] a, b;
    int base, st_a, st_b, ac_a, ac_b;
    int ua [8] = '{0, 1, 2, 5, 4, 6, 7, 3};
    bit pa [8] = '{1, 1, 0, 0, 1, 1, 1, 1};
    for (int j = 0; j < 8; j++) a[j*32 +: 32] = mk(48 + j, ua[j], pa[j]);
    b[31:0] = mk(64, 0, 1'b0);
    for (int j = 1; j < 8; j++) b[j*32 +: 32] = mk(64 + j, j, j != 7);
    e_n = 0; model_pkt(a); model_pkt(b);
    base = m_n;
    send(32'h0000_0600, a, st_a, ac_a);
    send(32'h0000_0620, b, st_b, ac_b);
    drain();
    check(st_a == 0, "R7", "first packet stall", 64'(st_a), 64'd0);
    check(st_b == 2, "R7", "second packet held off", 64'(st_b), 64'd2);
    check(m_val[base+2] == 8'hD8, "R4", "last group stops at word 7", 64'(m_val[base+2]), 64'hD8);
    check(m_val[base+3] == 8'h01, "R4", "next packet starts fresh", 64'(m_val[base+3]), 64'h01);
    compare(base, ac_a, "back-to-back");
  endtask

  task automatic t_conflict();
    logic [255:0] p;
    int base, st, ac;
    int uc [8] = '{2, 2, 6, 1, 1, 1, 0, 3};
    bit pc [8] = '{1, 1, 0, 1, 1, 0, 1, 0};
    for (int j = 0; j < 8; j++) p[j*32 +: 32] = mk(80 + j, uc[j], pc[j]);
    e_n = 0; model_pkt(p);
    base = m_n;
    send(32'h0000_0800, p, st, ac);
    drain();
    check(m_ins[base][2*32 +: 32] == p[31:0], "R8", "lowest claimant kept",
          64'(m_ins[base][2*32 +: 32]), 64'(p[31:0]));
    check(m_conf[base+2] == 1'b0, "R8", "clean packet no conflict", 64'(m_conf[base+2]), 64'd0);
    compare(base, ac, "conflict");
  endtask

  task automatic t_misalign();
    logic [255:0] p;
    int base, st, ac, m0;
    for (int j = 0; j < 8; j++) p[j*32 +: 32] = mk(96 + j, j, j[0]);
    m0 = mis_n;
    send(32'h0000_0A00, p, st, ac);
    drain();
    check(mis_n == m0, "R9", "aligned address no flag", 64'(mis_n - m0), 64'd0);
    e_n = 0; model_pkt(p);
    base = m_n; m0 = mis_n;
    send(32'h0000_0A04, p, st, ac);
    drain();
    check(mis_n == m0 + 1, "R9", "misaligned pulse count", 64'(mis_n - m0), 64'd1);
    check(mis_cyc == ac + 1, "R9", "misaligned pulse cycle", 64'(mis_cyc), 64'(ac + 1));
    compare(base, ac, "misaligned");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_serial();
    t_parallel();
    t_back_to_back();
    t_conflict();
    t_misalign();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule